// File: doc/BRIEF.md
# Current-Mode PWM Cycle Controller

This block decides, one switching period at a time, when the power-switch gate of a peak-current-mode converter is enabled. A cycle-start pulse from the oscillator turns the gate on. The pulse then ends on the first of these events: the current-sense comparator trips after the leading-edge blanking interval, the maximum-duty window closes, a skip request arrives, or the block is disabled.

The block also computes the digital modulation reference handed to the current comparator's DAC. That reference is the smaller of two values. The first is a soft-start ramp that climbs from zero to full scale and then holds. The second is the feedback code divided by three. A restart input brings the ramp back to zero and keeps the gate off until the next cycle start.

Top module: `pwm_cycle_ctrl`

## Requirements
- R1: While `rst_n` is low, `gate_en` is 0 and `mod_ref` is 0.
- R2: A cycle-start pulse sampled with `run_en` high, `duty_win` high, `skip_req` low and no restart hold makes `gate_en` 1 at the next clock edge.
- R3: With the gate on and no other turn-off cause, `cs_trip` sampled after blanking has ended turns `gate_en` off at that edge. Without a trip, the gate stays on.
- R4: `cs_trip` has no effect during the first `BLANK_CYC` clock cycles in which `gate_en` is 1. A trip held from turn-on therefore gives a pulse of exactly `BLANK_CYC`+1 cycles.
- R5: `duty_win` sampled low forces `gate_en` to 0 at that edge, and it also blocks a cycle start in the same cycle.
- R6: `skip_req` sampled high blocks a new pulse and ends a pulse in progress at that edge.
- R7: `run_en` sampled low blocks a new pulse and ends a pulse in progress at that edge.
- R8: `mod_ref` equals the minimum of the soft-start ramp and `fb_code`/3 (integer division). Before the minimum is taken, the quotient is saturated to 1023.
- R9: The ramp is a 10-bit code, and 1023 stands for full scale. It advances by 1 every `SS_DIV` clock edges after reset or restart, so after n edges it is min(n/`SS_DIV`, 1023). Once it reaches 1023 it stays there.
- R10: `ss_restart` sampled high clears the ramp to 0 and forces `gate_en` to 0. The gate then stays off until a later cycle start; a cycle start in the same cycle as the restart is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Block enable; low keeps the gate off |
| cyc_start | input | 1 | One-clock pulse at the start of each switching period |
| duty_win | input | 1 | High during the allowed on-time portion of the period |
| cs_trip | input | 1 | Current-sense comparator output, high when current has reached the reference |
| skip_req | input | 1 | Light-load skip request |
| ss_restart | input | 1 | Restarts soft-start and holds the gate off for the current period |
| fb_code | input | FB_W | Feedback code |
| gate_en | output | 1 | Gate-drive enable |
| mod_ref | output | 10 | Modulation reference code for the current comparator |

## Verification
The first pattern holds the trip input high from the moment the gate turns on. This separates a correct blanking length from a mask that is too short or too long, because the pulse width then equals the blanking count plus one. The next patterns end a pulse by closing the window, by skip, by disable or by restart. Each of these lines up a single cause against a plain cycle start, so a turn-off source that is missing or given the wrong priority shows up alone. The reference is compared on every cycle against a model of the ramp while the feedback code sits above, inside and below the ramp. This shows whether the minimum, the saturation, the step rate and the hold at full scale are each right.

// File: rtl/pwm_cycle_pkg.sv
package pwm_cycle_pkg;
    localparam int REF_W = 10;
    typedef logic [REF_W-1:0] ref_code_t;
    localparam ref_code_t REF_FULL = '1;

    typedef struct packed {
        logic gate;      // output latch
        logic hold_off;  // set by restart, cleared by next cycle start
    } gate_st_t;
endpackage

// File: rtl/pcc_softstart.sv
module pcc_softstart
    import pwm_cycle_pkg::*;
#(
    parameter int SS_DIV = 1173
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      restart,
    output ref_code_t ramp
);
    localparam int DIV_W = (SS_DIV > 1) ? $clog2(SS_DIV) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SS_DIV - 1);

    typedef struct packed {
        logic [DIV_W-1:0] div;
        ref_code_t        lvl;
    } ss_st_t;

    ss_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (restart) begin
            st_d.div = '0;
            st_d.lvl = '0;
        end else if (st_q.div == DIV_LAST) begin
            st_d.div = '0;
            if (st_q.lvl != REF_FULL) st_d.lvl = st_q.lvl + 1'b1;
        end else begin
            st_d.div = st_q.div + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ramp = st_q.lvl;

    // R9: ramp never falls unless restarted
    p_ramp_monotone_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !restart |=> (ramp >= $past(ramp)));
    // R10: restart brings ramp to zero
    p_restart_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (ramp == '0));
endmodule

// File: rtl/pcc_ref_select.sv
module pcc_ref_select
    import pwm_cycle_pkg::*;
#(
    parameter int FB_W = 12
) (
    input  logic [FB_W-1:0] fb_code,
    input  ref_code_t       ramp,
    output ref_code_t       mod_ref
);
    logic [FB_W-1:0] third;
    ref_code_t       fb_ref;

    assign third = fb_code / FB_W'(3);

    generate
        if (FB_W >= REF_W) begin : g_sat
            assign fb_ref = (third > FB_W'(REF_FULL)) ? REF_FULL : third[REF_W-1:0];
        end else begin : g_ext
            assign fb_ref = REF_W'(third);
        end
    endgenerate

    assign mod_ref = (ramp < fb_ref) ? ramp : fb_ref;
endmodule

// File: rtl/pcc_blank.sv
module pcc_blank #(
    parameter int BLANK_CYC = 46
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic blank_done
);
    localparam int CNT_W = $clog2(BLANK_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(BLANK_CYC);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)              cnt_d = CNT_INIT;
        else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign blank_done = (cnt_q == '0);

    // R4: a fresh turn-on always opens a blanking interval
    p_blank_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !blank_done);
endmodule

// File: rtl/pwm_cycle_ctrl.sv
module pwm_cycle_ctrl
    import pwm_cycle_pkg::*;
#(
    parameter int FB_W      = 12,
    parameter int BLANK_CYC = 46,
    parameter int SS_DIV    = 1173
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run_en,
    input  logic            cyc_start,
    input  logic            duty_win,
    input  logic            cs_trip,
    input  logic            skip_req,
    input  logic            ss_restart,
    input  logic [FB_W-1:0] fb_code,
    output logic            gate_en,
    output logic [9:0]      mod_ref
);
    gate_st_t  st_d, st_q;
    logic      set_ev, kill, trip_ok, blank_done;
    ref_code_t ramp;

    pcc_softstart #(.SS_DIV(SS_DIV)) u_ss (
        .clk(clk), .rst_n(rst_n), .restart(ss_restart), .ramp(ramp)
    );

    pcc_ref_select #(.FB_W(FB_W)) u_ref (
        .fb_code(fb_code), .ramp(ramp), .mod_ref(mod_ref)
    );

    pcc_blank #(.BLANK_CYC(BLANK_CYC)) u_blank (
        .clk(clk), .rst_n(rst_n), .load(set_ev), .blank_done(blank_done)
    );

    always_comb begin
        st_d    = st_q;
        set_ev  = 1'b0;
        kill    = !run_en || skip_req || !duty_win || ss_restart
                  || (st_q.hold_off && !cyc_start);
        trip_ok = st_q.gate && cs_trip && blank_done;

        if (ss_restart)     st_d.hold_off = 1'b1;
        else if (cyc_start) st_d.hold_off = 1'b0;

        if (kill) begin
            st_d.gate = 1'b0;
        end else if (cyc_start) begin
            st_d.gate = 1'b1;
            set_ev    = 1'b1;
        end else if (trip_ok) begin
            st_d.gate = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign gate_en = st_q.gate;

    // R2: gate only rises after a cycle start
    p_rise_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_en) |-> $past(cyc_start));
    // R4: within blanking, an unopposed pulse survives any trip
    p_blank_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_en && !blank_done && run_en && duty_win && !skip_req && !ss_restart)
        |=> gate_en);
    // R5: closed window forces gate off
    p_window_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !duty_win |=> !gate_en);
    // R6: skip forces gate off
    p_skip_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        skip_req |=> !gate_en);
    // R7: disable forces gate off
    p_run_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> !gate_en);
    // R10: restart forces gate off
    p_restart_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ss_restart |=> !gate_en);
endmodule

// File: tb/pwm_cycle_ctrl_tb_top.sv
module pwm_cycle_ctrl_tb_top;
    localparam int FB_W  = 12;
    localparam int BLANK = 5;
    localparam int SSD   = 4;

    logic clk = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    logic            rst_n, run_en, cyc_start, duty_win, cs_trip, skip_req, ss_restart;
    logic [FB_W-1:0] fb_code;
    logic            gate_en;
    logic [9:0]      mod_ref;

    pwm_cycle_ctrl #(.FB_W(FB_W), .BLANK_CYC(BLANK), .SS_DIV(SSD)) dut_i (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .cyc_start(cyc_start),
        .duty_win(duty_win), .cs_trip(cs_trip), .skip_req(skip_req),
        .ss_restart(ss_restart), .fb_code(fb_code), .gate_en(gate_en), .mod_ref(mod_ref)
    );

    typedef struct {
        int    when;
        logic  gate;
        string tag;
    } exp_t;

    exp_t sb_q[$];
    exp_t e;
    int   total = 0, bad = 0, cyc = 0, ss_edges = 0, er = 0;
    bit   done = 1'b0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n || ss_restart) ss_edges <= 0;
        else                      ss_edges <= ss_edges + 1;
    end

    function automatic int ramp_model();
        int r = ss_edges / SSD;
        if (r > 1023) r = 1023;
        return r;
    endfunction

    function automatic int fb_model();
        int f = int'(fb_code) / 3;
        if (f > 1023) f = 1023;
        return f;
    endfunction

    task automatic chk(bit ok, string tag, int act, int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, expv, cyc);
        end
    endtask

    // monitor: sample away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            if (!rst_n) chk(gate_en == 1'b0, "R1 gate in reset", int'(gate_en), 0);
            er = (ramp_model() < fb_model()) ? ramp_model() : fb_model();
            if (!rst_n)
                chk(int'(mod_ref) == 0, "R1 ref in reset", int'(mod_ref), 0);
            else if (ramp_model() <= fb_model())
                chk(int'(mod_ref) == er, "R9 ramp level", int'(mod_ref), er);
            else
                chk(int'(mod_ref) == er, "R8 feedback minimum", int'(mod_ref), er);
            while (sb_q.size() > 0 && sb_q[0].when <= cyc) begin
                e = sb_q.pop_front();
                if (e.when < cyc) chk(1'b0, {e.tag, " missed"}, cyc, e.when);
                else chk(gate_en == e.gate, e.tag, int'(gate_en), int'(e.gate));
            end
        end
    end

    task automatic tick(int n = 1);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic expect_g(int lat, logic g, string tag);
        exp_t x;
        x.when = cyc + lat;
        x.gate = g;
        x.tag  = tag;
        sb_q.push_back(x);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            bad++;
            total++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 0; run_en = 1; cyc_start = 0; duty_win = 1; cs_trip = 0;
        skip_req = 0; ss_restart = 0; fb_code = 12'd3000;
        tick(4);
        rst_n = 1;
        tick(2);

        // R2 R3 R4: trip held from turn-on, pulse lasts BLANK+1 cycles
        cyc_start = 1; cs_trip = 1;
        for (int k = 1; k <= BLANK + 1; k++)
            expect_g(k, 1'b1, (k == 1) ? "R2 set on cycle start" : "R4 trip ignored in blanking");
        expect_g(BLANK + 2, 1'b0, "R3 trip ends pulse");
        tick();
        cyc_start = 0;
        tick(BLANK + 3);
        cs_trip = 0;
        tick(2);

        // R3 R5: no trip keeps gate on, closing window ends it
        cyc_start = 1;
        expect_g(1, 1'b1, "R2 set on cycle start");
        tick();
        cyc_start = 0;
        tick(BLANK + 3);
        expect_g(0, 1'b1, "R3 gate held without trip");
        duty_win = 0;
        expect_g(1, 1'b0, "R5 window end forces off");
        tick(2);
        cyc_start = 1;
        expect_g(1, 1'b0, "R5 start blocked outside window");
        tick();
        cyc_start = 0; duty_win = 1;
        tick(2);

        // R6: skip
        skip_req = 1; cyc_start = 1;
        expect_g(1, 1'b0, "R6 skip blocks pulse");
        tick();
        cyc_start = 0;
        tick(2);
        skip_req = 0;
        cyc_start = 1;
        expect_g(1, 1'b1, "R2 set after skip released");
        tick();
        cyc_start = 0;
        tick(2);
        skip_req = 1;
        expect_g(1, 1'b0, "R6 skip ends pulse");
        tick(2);
        skip_req = 0;
        tick();

        // R7: disable
        run_en = 0; cyc_start = 1;
        expect_g(1, 1'b0, "R7 disabled blocks pulse");
        tick();
        run_en = 1;
        expect_g(1, 1'b1, "R2 set on cycle start");
        tick();
        cyc_start = 0;
        tick(2);
        run_en = 0;
        expect_g(1, 1'b0, "R7 disable ends pulse");
        tick(2);
        run_en = 1;
        tick();

        // R10: restart
        cyc_start = 1;
        expect_g(1, 1'b1, "R2 set on cycle start");
        tick();
        cyc_start = 0;
        tick(2);
        ss_restart = 1;
        expect_g(1, 1'b0, "R10 restart forces off");
        tick();
        ss_restart = 0;
        expect_g(1, 1'b0, "R10 held off");
        expect_g(2, 1'b0, "R10 held off");
        expect_g(3, 1'b0, "R10 held off");
        tick(3);
        cyc_start = 1;
        expect_g(1, 1'b1, "R10 next cycle start resumes");
        tick();
        cyc_start = 0;
        tick(2);
        ss_restart = 1; cyc_start = 1;
        expect_g(1, 1'b0, "R10 same-cycle start ignored");
        tick();
        ss_restart = 0; cyc_start = 0;
        expect_g(1, 1'b0, "R10 held off");
        tick();
        cyc_start = 1;
        expect_g(1, 1'b1, "R10 later start resumes");
        tick();
        cyc_start = 0; cs_trip = 1;
        tick(BLANK + 3);
        cs_trip = 0;

        // R8 R9: ramp crosses feedback, saturates, then feedback limits
        tick(4200);
        fb_code = 12'd4095;
        tick(20);
        fb_code = 12'd1500;
        tick(5);
        fb_code = 12'd151;
        tick(5);
        fb_code = 12'd2;
        tick(5);
        fb_code = 12'd3000;
        tick(3);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule